// File: doc/BRIEF.md
# Serial EEPROM Address Pointer Controller

This block tracks the byte pointer of a single-wire serial EEPROM slave and sequences its commands. A bit-level front end, outside this block, has already turned the wire activity into events: a received byte (`byte_valid` with `rx_byte`), a master acknowledge (`mak`), a master no-acknowledge (`nomak`) and a standby pulse (`standby`). From these events the controller follows a frame made of a header byte, a device-select byte, a command byte, an optional address byte and then data bytes. It keeps the pointer and decides, for each event, whether the pointer is loaded, stepped, wrapped inside its page or left unchanged.

Towards the byte array the block drives the current pointer as `mem_addr`. It raises `wr_en`, with the incoming byte on `wr_data`, for each byte a write command delivers. It pulses `rd_en` when the array must present the next byte of a read. Three commands are supported. The plain read loads the pointer from one address byte. The write loads the pointer the same way and then stores data bytes. The current-pointer read skips the address byte and continues from wherever the pointer was left.

The sequencer states are S_IDLE (wait for the header), S_DEV (wait for the device-select byte), S_CMD (wait for the command byte), S_ADDR (wait for the address byte), S_ADDR_ACK (wait for the acknowledge that commits the address), S_DATA (wait for a data byte slot) and S_DATA_ACK (wait for the acknowledge that ends that slot). Transitions:
- S_IDLE→S_DEV on a header byte.
- S_DEV→S_CMD on a matching device byte, or back to S_IDLE on any other byte.
- S_CMD→S_ADDR on a read or write code, S_CMD→S_DATA on the current-pointer read code, and S_CMD→S_IDLE on any other code.
- S_ADDR→S_ADDR_ACK on a byte.
- S_ADDR_ACK→S_DATA on `mak`, or S_ADDR_ACK→S_IDLE on `nomak`.
- S_DATA→S_DATA_ACK on a byte.
- S_DATA_ACK→S_DATA on `mak`, or S_DATA_ACK→S_IDLE on `nomak`.
- Any state→S_IDLE on `standby`, which takes priority over every other event.

Top module: `eep_ptr_ctrl`

## Requirements
- R1: A frame opens only with header byte 0x55 followed by device byte 0xA0. Any other header byte leaves the sequencer idle, and any other device byte returns it to idle. Bytes that follow in either case neither load the pointer nor raise a strobe.
- R2: Command 0x03 (read) and command 0x6C (write) each take one address byte. The pointer is loaded with that byte on the `mak` that follows it. A `nomak` in that slot leaves the pointer unchanged and returns to idle.
- R3: In a write, each data byte raises `wr_en` for exactly the cycle in which `byte_valid` is high. In that cycle `mem_addr` holds the current pointer and `wr_data` equals `rx_byte`.
- R4: The pointer increases by one on the `mak` or `nomak` that follows each data byte. In a read, 0xFF steps to 0x00.
- R5: In a write, the step keeps bits 7:4 of the pointer and wraps bits 3:0 inside the 16-byte page (0xXF goes to 0xX0).
- R6: A standby pulse returns the sequencer to idle. The pointer does not change and no write follows until a new frame opens.
- R7: Command 0x06 (current-pointer read) takes no address byte. Its first `rd_en` presents the pointer left by the previous command.
- R8: `rd_en` is a one-cycle pulse one clock after an accepted current-pointer command, an address `mak` in a read, or a data `mak` in a read. `mem_addr` holds the byte address during that pulse. After `nomak` no further `rd_en` occurs. `wr_en` and `rd_en` are never high together.
- R9: An unrecognised command byte returns the sequencer to idle with the pointer unchanged.
- R10: A `mak` or `nomak` that arrives outside an acknowledge slot (in idle, or in a data slot before its byte) leaves the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the sequencer |
| byte_valid | input | 1 | One-cycle pulse: a byte slot has completed |
| rx_byte | input | 8 | Byte received from the master |
| mak | input | 1 | One-cycle pulse: master acknowledge edge |
| nomak | input | 1 | One-cycle pulse: master no-acknowledge edge |
| standby | input | 1 | One-cycle pulse: standby pulse seen on the line |
| mem_addr | output | ADDR_W | Current pointer, used as the array address |
| wr_en | output | 1 | Write strobe for the page buffer |
| wr_data | output | 8 | Byte to be written |
| rd_en | output | 1 | Read strobe for the array |

## Verification
The bench builds the block with ADDR_W = 8 and PAGE_W = 4. With these values it can issue a read from every one of the 256 start addresses, so the step from 0xFF to 0x00 and every page boundary come into reach. Writes of 18 bytes are issued from start addresses spread across the whole array, so every write crosses its 16-byte page wrap and the upper pointer bits must survive it. Framing errors, unknown commands, standby pulses and stray acknowledges are then aimed at a known pointer value.

// File: rtl/eep_ptr_pkg.sv
package eep_ptr_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DEV,
        S_CMD,
        S_ADDR,
        S_ADDR_ACK,
        S_DATA,
        S_DATA_ACK
    } seq_state_e;

    localparam logic [7:0] HDR_CODE    = 8'h55;
    localparam logic [7:0] DEV_CODE    = 8'hA0;
    localparam logic [7:0] CMD_READ    = 8'h03;
    localparam logic [7:0] CMD_WRITE   = 8'h6C;
    localparam logic [7:0] CMD_CUR_RD  = 8'h06;

endpackage

// File: rtl/eep_ptr_reg.sv
module eep_ptr_reg #(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    input  logic              page_wrap,
    output logic [ADDR_W-1:0] ptr
);

    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] lin_inc;
    logic [ADDR_W-1:0] pg_inc;

    assign lin_inc = ptr_q + ADDR_W'(1);

    generate
        if (PAGE_W < ADDR_W) begin : g_paged
            logic [PAGE_W-1:0] lo_nxt;
            assign lo_nxt = ptr_q[PAGE_W-1:0] + PAGE_W'(1);
            assign pg_inc = {ptr_q[ADDR_W-1:PAGE_W], lo_nxt};
        end else begin : g_flat
            assign pg_inc = lin_inc;
        end
    endgenerate

    // Value after reset is a don't-care; zero is chosen for determinism.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (load) begin
            ptr_q <= load_val;
        end else if (step) begin
            ptr_q <= page_wrap ? pg_inc : lin_inc;
        end
    end

    assign ptr = ptr_q;

endmodule

// File: rtl/eep_ptr_fsm.sv
module eep_ptr_fsm
    import eep_ptr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic [7:0]        rx_byte,
    input  logic              mak,
    input  logic              nomak,
    input  logic              standby,
    output logic              ptr_load,
    output logic [ADDR_W-1:0] load_val,
    output logic              ptr_step,
    output logic              page_wrap,
    output logic              wr_en,
    output logic              rd_en
);

    seq_state_e state_q, state_d;
    logic       wr_mode_q, wr_mode_d;
    logic [7:0] addr_q, addr_d;
    logic       rd_en_q, rd_go;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            wr_mode_q <= 1'b0;
            addr_q    <= '0;
            rd_en_q   <= 1'b0;
        end else begin
            state_q   <= state_d;
            wr_mode_q <= wr_mode_d;
            addr_q    <= addr_d;
            rd_en_q   <= rd_go;
        end
    end

    // Next state
    always_comb begin
        state_d   = state_q;
        wr_mode_d = wr_mode_q;
        addr_d    = addr_q;
        rd_go     = 1'b0;
        if (standby) begin
            state_d = S_IDLE;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (byte_valid && rx_byte == HDR_CODE) state_d = S_DEV;
                end
                S_DEV: begin
                    if (byte_valid) state_d = (rx_byte == DEV_CODE) ? S_CMD : S_IDLE;
                end
                S_CMD: begin
                    if (byte_valid) begin
                        if (rx_byte == CMD_CUR_RD) begin
                            state_d   = S_DATA;
                            wr_mode_d = 1'b0;
                            rd_go     = 1'b1;
                        end else if (rx_byte == CMD_READ) begin
                            state_d   = S_ADDR;
                            wr_mode_d = 1'b0;
                        end else if (rx_byte == CMD_WRITE) begin
                            state_d   = S_ADDR;
                            wr_mode_d = 1'b1;
                        end else begin
                            state_d   = S_IDLE;
                        end
                    end
                end
                S_ADDR: begin
                    if (byte_valid) begin
                        addr_d  = rx_byte;
                        state_d = S_ADDR_ACK;
                    end
                end
                S_ADDR_ACK, S_DATA_ACK: begin
                    if (mak) begin
                        state_d = S_DATA;
                        rd_go   = !wr_mode_q;
                    end else if (nomak) begin
                        state_d = S_IDLE;
                    end
                end
                S_DATA: begin
                    if (byte_valid) state_d = S_DATA_ACK;
                end
                default: state_d = S_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        ptr_load = 1'b0;
        ptr_step = 1'b0;
        wr_en    = 1'b0;
        unique case (state_q)
            S_ADDR_ACK: ptr_load = !standby && mak;
            S_DATA_ACK: ptr_step = !standby && (mak || nomak);
            S_DATA:     wr_en    = !standby && byte_valid && wr_mode_q;
            default: ;
        endcase
    end

    assign load_val  = ADDR_W'(addr_q);
    assign page_wrap = wr_mode_q;
    assign rd_en     = rd_en_q;

endmodule

// File: rtl/eep_ptr_ctrl.sv
module eep_ptr_ctrl #(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic [7:0]        rx_byte,
    input  logic              mak,
    input  logic              nomak,
    input  logic              standby,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              wr_en,
    output logic [7:0]        wr_data,
    output logic              rd_en
);

    logic              ptr_load;
    logic [ADDR_W-1:0] load_val;
    logic              ptr_step;
    logic              page_wrap;

    eep_ptr_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_valid (byte_valid),
        .rx_byte    (rx_byte),
        .mak        (mak),
        .nomak      (nomak),
        .standby    (standby),
        .ptr_load   (ptr_load),
        .load_val   (load_val),
        .ptr_step   (ptr_step),
        .page_wrap  (page_wrap),
        .wr_en      (wr_en),
        .rd_en      (rd_en)
    );

    eep_ptr_reg #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ptr_load),
        .load_val  (load_val),
        .step      (ptr_step),
        .page_wrap (page_wrap),
        .ptr       (mem_addr)
    );

    assign wr_data = rx_byte;

endmodule

// File: rtl/eep_ptr_ctrl_chk.sv
module eep_ptr_ctrl_chk #(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mak,
    input logic              nomak,
    input logic              standby,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              wr_en,
    input logic              rd_en
);

    p_standby_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> $stable(mem_addr));

    p_move_on_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mem_addr) |-> $past(mak || nomak));

    p_nomak_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(nomak) && !$stable(mem_addr)) |->
        (mem_addr[PAGE_W-1:0] == PAGE_W'($past(mem_addr[PAGE_W-1:0]) + 1'b1)));

    p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && rd_en));

    p_rd_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !rd_en);

    p_wr_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

endmodule

bind eep_ptr_ctrl eep_ptr_ctrl_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mak      (mak),
    .nomak    (nomak),
    .standby  (standby),
    .mem_addr (mem_addr),
    .wr_en    (wr_en),
    .rd_en    (rd_en)
);

// File: tb/eep_ptr_ctrl_tb_top.sv
`timescale 1ns/1ps
module eep_ptr_ctrl_tb_top;

    localparam logic [7:0] T_HDR = 8'h55, T_DEV = 8'hA0;
    localparam logic [7:0] T_RD = 8'h03, T_WR = 8'h6C, T_CUR = 8'h06;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       mak = 1'b0, nomak = 1'b0, standby = 1'b0;
    logic [7:0] mem_addr;
    logic       wr_en, rd_en;
    logic [7:0] wr_data;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    eep_ptr_ctrl #(.ADDR_W(8), .PAGE_W(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .rx_byte(rx_byte),
        .mak(mak), .nomak(nomak), .standby(standby),
        .mem_addr(mem_addr), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Byte slot: wr strobe sampled in-cycle, rd strobe and pointer after the edge
    task automatic put_byte(input logic [7:0] b, output logic w, output logic [7:0] wa,
                            output logic [7:0] wd, output logic r, output logic [7:0] ra);
        byte_valid = 1'b1; rx_byte = b;
        #1; w = wr_en; wa = mem_addr; wd = wr_data;
        @(negedge clk); byte_valid = 1'b0;
        #1; r = rd_en; ra = mem_addr;
    endtask

    // kind: 0 mak, 1 nomak, 2 standby
    task automatic pulse(input int kind, output logic r, output logic [7:0] ra);
        if (kind == 0) mak = 1'b1; else if (kind == 1) nomak = 1'b1; else standby = 1'b1;
        @(negedge clk); mak = 1'b0; nomak = 1'b0; standby = 1'b0;
        #1; r = rd_en; ra = mem_addr;
    endtask

    task automatic open_frame(input logic [7:0] cmd, output logic r, output logic [7:0] ra);
        logic w; logic [7:0] wa, wd;
        pulse(2, r, ra);
        put_byte(T_HDR, w, wa, wd, r, ra);
        put_byte(T_DEV, w, wa, wd, r, ra);
        put_byte(cmd, w, wa, wd, r, ra);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic w, r; logic [7:0] wa, wd, ra;
        int exp_ptr;
        repeat (3) @(negedge clk);
        #1;
        chk(!wr_en && !rd_en, "R8 reset strobes", {wr_en, rd_en}, 0);
        rst_n = 1'b1;
        @(negedge clk); #1;

        // Read sweep over every start address
        for (int a = 0; a < 256; a++) begin
            open_frame(T_RD, r, ra);
            put_byte(a[7:0], w, wa, wd, r, ra);
            chk(!w, "R2 no write on address byte", w, 0);
            pulse(0, r, ra);
            chk(r && ra == a[7:0], "R2/R8 address load", ra, a);
            put_byte(8'hFF, w, wa, wd, r, ra);
            chk(!w, "R8 no write in read", w, 0);
            pulse(0, r, ra);
            chk(r && ra == 8'((a + 1) & 255), "R4 read step", ra, (a + 1) & 255);
            put_byte(8'hFF, w, wa, wd, r, ra);
            pulse(1, r, ra);
            chk(!r && ra == 8'((a + 2) & 255), "R4/R8 nomak step", {r, ra}, (a + 2) & 255);
            open_frame(T_CUR, r, ra);
            chk(r && ra == 8'((a + 2) & 255), "R7 current read", {r, ra}, 256 + ((a + 2) & 255));
            put_byte(8'hFF, w, wa, wd, r, ra);
            pulse(2, r, ra);
            chk(ra == 8'((a + 2) & 255), "R6 standby no step", ra, (a + 2) & 255);
        end

        // Write sweep: 18-byte bursts crossing the page wrap
        for (int a = 0; a < 256; a += 7) begin
            open_frame(T_WR, r, ra);
            put_byte(a[7:0], w, wa, wd, r, ra);
            pulse(0, r, ra);
            chk(!r && ra == a[7:0], "R2/R8 write address load", {r, ra}, a);
            for (int i = 0; i < 18; i++) begin
                int e;
                logic [7:0] d;
                e = (a & 8'hF0) | ((a + i) & 4'hF);
                d = 8'(a ^ (i * 3));
                put_byte(d, w, wa, wd, r, ra);
                chk(w && wa == e[7:0] && wd == d, "R3/R5 write byte", {w, wa, wd}, {1'b1, e[7:0], d});
                pulse((i == 17) ? 1 : 0, r, ra);
                chk(!r, "R8 no read in write", r, 0);
            end
            exp_ptr = (a & 8'hF0) | ((a + 18) & 4'hF);
            chk(ra == exp_ptr[7:0], "R5 page wrap end", ra, exp_ptr);
        end

        // Standby in the middle of a write
        open_frame(T_WR, r, ra);
        put_byte(8'h20, w, wa, wd, r, ra);
        pulse(0, r, ra);
        put_byte(8'h5A, w, wa, wd, r, ra);
        chk(w && wa == 8'h20, "R3 write at loaded address", wa, 8'h20);
        pulse(2, r, ra);
        chk(ra == 8'h20, "R6 standby after data", ra, 8'h20);
        put_byte(8'h77, w, wa, wd, r, ra);
        chk(!w, "R6 no write after standby", w, 0);
        exp_ptr = 8'h20;

        // Bad header
        pulse(2, r, ra);
        put_byte(8'h54, w, wa, wd, r, ra);
        put_byte(T_DEV, w, wa, wd, r, ra);
        put_byte(T_RD, w, wa, wd, r, ra);
        put_byte(8'h40, w, wa, wd, r, ra);
        pulse(0, r, ra);
        chk(!r && ra == exp_ptr[7:0], "R1 bad header", {r, ra}, exp_ptr);

        // Bad device byte
        pulse(2, r, ra);
        put_byte(T_HDR, w, wa, wd, r, ra);
        put_byte(8'hA2, w, wa, wd, r, ra);
        put_byte(T_RD, w, wa, wd, r, ra);
        put_byte(8'h40, w, wa, wd, r, ra);
        pulse(0, r, ra);
        chk(!r && ra == exp_ptr[7:0], "R1 bad device", {r, ra}, exp_ptr);

        // Unknown command
        open_frame(8'h11, r, ra);
        chk(!r, "R9 no read on unknown command", r, 0);
        put_byte(8'h40, w, wa, wd, r, ra);
        pulse(0, r, ra);
        chk(!r && ra == exp_ptr[7:0], "R9 unknown command", {r, ra}, exp_ptr);

        // nomak after address byte
        open_frame(T_RD, r, ra);
        put_byte(8'h40, w, wa, wd, r, ra);
        pulse(1, r, ra);
        chk(!r && ra == exp_ptr[7:0], "R2 nomak on address", {r, ra}, exp_ptr);

        // Stray acknowledges
        open_frame(T_CUR, r, ra);
        chk(r && ra == exp_ptr[7:0], "R7 current read after aborts", {r, ra}, 256 + exp_ptr);
        pulse(0, r, ra);
        chk(!r && ra == exp_ptr[7:0], "R10 mak before data byte", {r, ra}, exp_ptr);
        pulse(1, r, ra);
        chk(ra == exp_ptr[7:0], "R10 nomak before data byte", ra, exp_ptr);
        pulse(2, r, ra);
        pulse(0, r, ra);
        pulse(1, r, ra);
        chk(!r && ra == exp_ptr[7:0], "R10 acks in idle", {r, ra}, exp_ptr);

        finish_run();
    end

endmodule